// File: doc/BRIEF.md
# Clock Fanout Output Control Logic

This block is the digital control core of a differential clock buffer with eight outputs. It decides, for each output, whether the output may toggle. It also selects the operating mode of the phase-locked loop (PLL) and holds the bus address that the device answers to. The serial bus engine, the analog PLL, the differential drivers and the three-level pin comparators are outside the block. Each three-level strap arrives already decoded as a 2-bit code: `00` is low, `01` is mid and `10` is high. The code `11` is read as mid.

An output toggles only when all of these hold: the power-good input is high, the output's enable pin is set, the output's enable register bit is set, and the PLL is either bypassed or reports lock. Each enable pin and the lock flag pass through a synchronizer. The run/stop gate itself changes only on a falling clock edge, so a leg never carries a shortened pulse. A small byte-wide register port holds the software enables, a software override of the PLL mode, and the input-frequency code. The bus address is decoded from its strap once, at the first clock on which power-good is seen high after reset.

Top module: `clkfan_ctrl`

## Requirements
- R1: While `pwrGood` is low, every bit of `difTrue` and `difComp` is 0 and `pllEn` is 0.
- R2: While power-good is high and the PLL condition of R3/R4 holds, output x runs only if its synchronized enable pin and bit x of register byte 2 are both 1. Byte 2 resets to 0xFF. A running output drives `difTrue[x]` equal to the clock and `difComp[x]` equal to its inverse.
- R3: In a PLL mode (low or high bandwidth), every output stays stopped until the synchronized `pllLock` is 1, and `pllEn` is 1 while power-good is high.
- R4: In bypass mode, `pllBypass` is 1 and `pllEn` is 0, and the outputs run without waiting for `pllLock`.
- R5: At the first clock edge after reset on which `pwrGood` is high, `busAddr` takes 7'h6B for `addrStrap` code 00, 7'h6C for codes 01 and 11, and 7'h6D for code 10. Before that edge, `busAddr` reads 0.
- R6: After the address has been captured, changes to the address strap and later falls and rises of `pwrGood` leave `busAddr` unchanged. Only `rstN` clears it.
- R7: The mode strap selects low bandwidth for code 00, bypass for codes 01 and 11, and high bandwidth for code 10 (`pllHiBw` = 1). Register byte 1 bits [7:6] read back this strap mode encoded as 00 for low bandwidth, 01 for bypass and 11 for high bandwidth.
- R8: When byte 1 bit 5 is 1, byte 1 bits [4:3] set the mode in place of the strap: 01 is bypass, 11 is high bandwidth, and any other value is low bandwidth.
- R9: Byte 3 bits [4:3] drive `freqSel`, which resets to 00. A write of code 11 leaves the previous value in place.
- R10: A change on an enable pin takes effect at the falling clock edge that follows the second rising edge after the change. During the high phase after that second rising edge, the output stays as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that is fanned out |
| rstN | input | 1 | Asynchronous active-low full reset |
| pwrGood | input | 1 | Power-good input; low means power down |
| oePin | input | 8 | Per-output enable pins, asynchronous |
| pllLock | input | 1 | PLL lock flag, asynchronous |
| addrStrap | input | 2 | Decoded three-level address strap |
| modeStrap | input | 2 | Decoded three-level PLL mode strap |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register byte index |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr` |
| difTrue | output | 8 | True leg of each output |
| difComp | output | 8 | Complement leg of each output |
| pllEn | output | 1 | PLL enable |
| pllBypass | output | 1 | PLL bypass select |
| pllHiBw | output | 1 | PLL high-bandwidth select |
| freqSel | output | 2 | Input frequency code (00 = 100 MHz, 01 = 50 MHz, 10 = 125 MHz) |
| busAddr | output | 7 | Captured 7-bit bus address |

## Verification
The bench builds the block with its default values: eight outputs and two-stage synchronizers. With these values, every enable-pin pattern can be checked as a full 8-bit mask on both legs. The two-stage latency of R10 can be probed edge by edge, comparing the high phase against the low phase that follows. The address scenarios apply full resets between strap codes, so the first-capture rule and the later ignoring of `pwrGood` toggles are each observed on `busAddr`.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

  localparam logic [1:0] MODE_LOBW = 2'b00;
  localparam logic [1:0] MODE_BYP  = 2'b01;
  localparam logic [1:0] MODE_HIBW = 2'b11;
  localparam logic [1:0] FREQ_RSVD = 2'b11;

  typedef struct packed {
    logic bypass;
    logic hiBw;
    logic addrCapture;
  } ctrlStb_t;

  function automatic logic [6:0] strapToAddr(input logic [1:0] code);
    case (code)
      2'b00:   strapToAddr = 7'h6B;
      2'b10:   strapToAddr = 7'h6D;
      default: strapToAddr = 7'h6C;
    endcase
  endfunction

  function automatic logic [1:0] strapToMode(input logic [1:0] code);
    case (code)
      2'b00:   strapToMode = MODE_LOBW;
      2'b10:   strapToMode = MODE_HIBW;
      default: strapToMode = MODE_BYP;
    endcase
  endfunction

endpackage

// File: rtl/clkfan_control.sv
module clkfan_control
  import clkfan_pkg::*;
#(
  parameter int NUM_OUT = 8,
  parameter int ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrGood,
  input  logic [1:0]        modeStrap,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic [NUM_OUT-1:0] oeBits,
  output logic [1:0]        freqSel,
  output ctrlStb_t          stb
);

  localparam logic [ADDR_W-1:0] BYTE_MODE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] BYTE_OE   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] BYTE_FREQ = ADDR_W'(3);

  logic              swSel;
  logic [1:0]        swMode;
  logic [NUM_OUT-1:0] oeReg;
  logic [1:0]        freqReg;
  logic              addrDone;
  logic [1:0]        strapMode;
  logic [1:0]        effMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swSel   <= 1'b0;
      swMode  <= MODE_LOBW;
      oeReg   <= '1;
      freqReg <= 2'b00;
    end else if (regWrEn) begin
      if (regAddr == BYTE_MODE) begin
        swSel  <= regWrData[5];
        swMode <= regWrData[4:3];
      end
      if (regAddr == BYTE_OE) begin
        oeReg <= regWrData[NUM_OUT-1:0];
      end
      if (regAddr == BYTE_FREQ && regWrData[4:3] != FREQ_RSVD) begin
        freqReg <= regWrData[4:3];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrDone <= 1'b0;
    end else if (pwrGood) begin
      addrDone <= 1'b1;
    end
  end

  always_comb begin
    strapMode = strapToMode(modeStrap);
    effMode   = swSel ? swMode : strapMode;
    stb.bypass      = (effMode == MODE_BYP);
    stb.hiBw        = (effMode == MODE_HIBW);
    stb.addrCapture = pwrGood && !addrDone;
  end

  always_comb begin
    regRdData = 8'h00;
    case (regAddr)
      BYTE_MODE: regRdData = {strapMode, swSel, swMode, 3'b000};
      BYTE_OE:   regRdData = 8'(oeReg);
      BYTE_FREQ: regRdData = {3'b000, freqReg, 3'b000};
      default:   regRdData = 8'h00;
    endcase
  end

  assign oeBits  = oeReg;
  assign freqSel = freqReg;

endmodule

// File: rtl/clkfan_datapath.sv
module clkfan_datapath
  import clkfan_pkg::*;
#(
  parameter int NUM_OUT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwrGood,
  input  logic [NUM_OUT-1:0] oePin,
  input  logic [NUM_OUT-1:0] oeBits,
  input  logic               pllLock,
  input  logic [1:0]         addrStrap,
  input  ctrlStb_t           stb,
  output logic [NUM_OUT-1:0] runGate,
  output logic [6:0]         busAddr
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_OUT-1:0] oeSync;
  logic [LAST:0]      lockChain;
  logic [NUM_OUT-1:0] runReq;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_sync
    logic [LAST:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[LAST-1:0], oePin[i]};
    end
    assign oeSync[i] = chain[LAST];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockChain <= '0;
    else       lockChain <= {lockChain[LAST-1:0], pllLock};
  end

  always_comb begin
    runReq = oeSync & oeBits & {NUM_OUT{pwrGood && (stb.bypass || lockChain[LAST])}};
  end

  // gate updates while the clock is low: no shortened high pulse
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) runGate <= '0;
    else       runGate <= runReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                busAddr <= 7'h00;
    else if (stb.addrCapture) busAddr <= strapToAddr(addrStrap);
  end

endmodule

// File: rtl/clkfan_ctrl.sv
module clkfan_ctrl
  import clkfan_pkg::*;
#(
  parameter int NUM_OUT     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwrGood,
  input  logic [NUM_OUT-1:0] oePin,
  input  logic               pllLock,
  input  logic [1:0]         addrStrap,
  input  logic [1:0]         modeStrap,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  output logic [NUM_OUT-1:0] difTrue,
  output logic [NUM_OUT-1:0] difComp,
  output logic               pllEn,
  output logic               pllBypass,
  output logic               pllHiBw,
  output logic [1:0]         freqSel,
  output logic [6:0]         busAddr
);

  ctrlStb_t           stb;
  logic [NUM_OUT-1:0] oeBits;
  logic [NUM_OUT-1:0] runGate;

  clkfan_control #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) control_i (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .modeStrap(modeStrap),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .oeBits(oeBits), .freqSel(freqSel), .stb(stb)
  );

  clkfan_datapath #(.NUM_OUT(NUM_OUT), .SYNC_STAGES(SYNC_STAGES)) datapath_i (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .oePin(oePin), .oeBits(oeBits),
    .pllLock(pllLock), .addrStrap(addrStrap), .stb(stb),
    .runGate(runGate), .busAddr(busAddr)
  );

  assign difTrue   = runGate & {NUM_OUT{clk & pwrGood}};
  assign difComp   = runGate & {NUM_OUT{~clk & pwrGood}};
  assign pllEn     = pwrGood & ~stb.bypass;
  assign pllBypass = stb.bypass;
  assign pllHiBw   = stb.hiBw;

endmodule

// File: rtl/clkfan_ctrl_checker.sv
module clkfan_ctrl_checker #(
  parameter int NUM_OUT = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               pwrGood,
  input logic [NUM_OUT-1:0] difTrue,
  input logic [NUM_OUT-1:0] difComp,
  input logic               pllEn,
  input logic               pllBypass,
  input logic               pllHiBw,
  input logic [1:0]         freqSel,
  input logic [6:0]         busAddr
);

  assert_power_down_R1: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |-> (difTrue == '0 && difComp == '0 && !pllEn));

  assert_bypass_pll_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    pllBypass |-> !pllEn);

  assert_mode_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    pllHiBw |-> !pllBypass);

  assert_addr_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != 7'h00) |=> $stable(busAddr));

  assert_freq_no_reserved_R9: assert property (@(posedge clk) disable iff (!rstN)
    freqSel != 2'b11);

  assert_legs_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    (difTrue & difComp) == '0);

endmodule

bind clkfan_ctrl clkfan_ctrl_checker #(.NUM_OUT(NUM_OUT)) checker_i (
  .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .difTrue(difTrue), .difComp(difComp),
  .pllEn(pllEn), .pllBypass(pllBypass), .pllHiBw(pllHiBw),
  .freqSel(freqSel), .busAddr(busAddr)
);

// File: tb/clkfan_ctrl_tb.sv
module clkfan_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       pwrGood;
  logic [7:0] oePin;
  logic       pllLock;
  logic [1:0] addrStrap;
  logic [1:0] modeStrap;
  logic       regWrEn;
  logic [1:0] regAddr;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic [7:0] difTrue;
  logic [7:0] difComp;
  logic       pllEn;
  logic       pllBypass;
  logic       pllHiBw;
  logic [1:0] freqSel;
  logic [6:0] busAddr;

  int checks = 0;
  int errors = 0;

  clkfan_ctrl dut_i (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .oePin(oePin), .pllLock(pllLock),
    .addrStrap(addrStrap), .modeStrap(modeStrap), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .difTrue(difTrue), .difComp(difComp), .pllEn(pllEn), .pllBypass(pllBypass),
    .pllHiBw(pllHiBw), .freqSel(freqSel), .busAddr(busAddr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // move to just after a falling edge before driving inputs
  task automatic toLow();
    @(negedge clk); #1;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    toLow();
  endtask

  // check both phases of one clock period against an expected run mask
  task automatic checkOut(input string req, input logic [7:0] mask);
    @(posedge clk); #2;
    check({req, " true leg high phase"}, difTrue, mask);
    check({req, " comp leg high phase"}, difComp, 8'h00);
    @(negedge clk); #2;
    check({req, " comp leg low phase"}, difComp, mask);
    check({req, " true leg low phase"}, difTrue, 8'h00);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    toLow();
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    toLow();
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    toLow();
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic doReset(input logic [1:0] aStrap);
    toLow();
    rstN = 1'b0; pwrGood = 1'b0; addrStrap = aStrap;
    toLow();
    rstN = 1'b1;
    toLow();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    doReset(2'b01);
    check("R1 outputs off in power down", {difTrue, difComp}, 16'h0);
    check("R1 pllEn low in power down", pllEn, 1'b0);
    check("R5 address zero before capture", busAddr, 7'h00);
    check("R9 freqSel reset", freqSel, 2'b00);
    regRead(2'd2, d);
    check("R2 enable byte reset", d, 8'hFF);
  endtask

  task automatic t_addr();
    doReset(2'b01);
    pwrGood = 1'b1;
    settle();
    check("R5 mid strap address", busAddr, 7'h6C);
    addrStrap = 2'b10; pwrGood = 1'b0;
    settle();
    pwrGood = 1'b1;
    settle();
    check("R6 address held after power-good toggle", busAddr, 7'h6C);
    doReset(2'b10);
    check("R6 full reset clears address", busAddr, 7'h00);
    pwrGood = 1'b1;
    settle();
    check("R5 high strap address", busAddr, 7'h6D);
    doReset(2'b00);
    pwrGood = 1'b1;
    settle();
    check("R5 low strap address", busAddr, 7'h6B);
  endtask

  task automatic t_lock();
    modeStrap = 2'b00; pllLock = 1'b0; oePin = 8'hFF;
    doReset(2'b00);
    pwrGood = 1'b1;
    settle();
    check("R3 pllEn high in PLL mode", pllEn, 1'b1);
    check("R7 low bandwidth select", {pllBypass, pllHiBw}, 2'b00);
    checkOut("R3 stopped before lock", 8'h00);
    toLow();
    pllLock = 1'b1;
    settle();
    checkOut("R3 running after lock", 8'hFF);
  endtask

  task automatic t_gate();
    toLow();
    oePin = 8'hF0;
    settle();
    checkOut("R2 pin mask", 8'hF0);
    regWrite(2'd2, 8'h3C);
    settle();
    checkOut("R2 pin and register mask", 8'h30);
    regWrite(2'd2, 8'hFF);
    toLow();
    oePin = 8'hFF;
    settle();
    checkOut("R2 all enabled", 8'hFF);
  endtask

  task automatic t_edge();
    toLow();
    oePin = 8'h0F;
    @(posedge clk); #2;
    check("R10 unchanged after first rise", difTrue, 8'hFF);
    @(posedge clk); #2;
    check("R10 unchanged during second high phase", difTrue, 8'hFF);
    @(negedge clk); #2;
    check("R10 change at following fall", difComp, 8'h0F);
    checkOut("R10 new mask steady", 8'h0F);
    toLow();
    oePin = 8'hFF;
    settle();
  endtask

  task automatic t_pwrdown();
    toLow();
    pwrGood = 1'b0;
    #1;
    check("R1 outputs off at once", {difTrue, difComp}, 16'h0);
    check("R1 pllEn off", pllEn, 1'b0);
    checkOut("R1 outputs stay off", 8'h00);
    toLow();
    pwrGood = 1'b1;
    settle();
  endtask

  task automatic t_bypass();
    logic [7:0] d;
    toLow();
    pllLock = 1'b0; modeStrap = 2'b01;
    settle();
    check("R4 bypass select", pllBypass, 1'b1);
    check("R4 pllEn low in bypass", pllEn, 1'b0);
    checkOut("R4 running without lock", 8'hFF);
    regRead(2'd1, d);
    check("R7 bypass readback", d[7:6], 2'b01);
    modeStrap = 2'b10;
    #1;
    check("R7 high bandwidth select", {pllBypass, pllHiBw}, 2'b01);
    regRead(2'd1, d);
    check("R7 high bandwidth readback", d[7:6], 2'b11);
    settle();
    checkOut("R3 stopped after lock loss", 8'h00);
  endtask

  task automatic t_sw();
    regWrite(2'd1, 8'h28);
    #1;
    check("R8 software bypass", {pllBypass, pllHiBw, pllEn}, 3'b100);
    regWrite(2'd1, 8'h38);
    #1;
    check("R8 software high bandwidth", {pllBypass, pllHiBw}, 2'b01);
    modeStrap = 2'b01;
    regWrite(2'd1, 8'h30);
    #1;
    check("R8 software code 10 is low bandwidth", {pllBypass, pllHiBw}, 2'b00);
    regWrite(2'd1, 8'h00);
    #1;
    check("R8 strap mode restored", pllBypass, 1'b1);
  endtask

  task automatic t_freq();
    logic [7:0] d;
    regWrite(2'd3, 8'h08);
    check("R9 write 01", freqSel, 2'b01);
    regWrite(2'd3, 8'h18);
    check("R9 reserved code rejected", freqSel, 2'b01);
    regWrite(2'd3, 8'h10);
    regRead(2'd3, d);
    check("R9 write 10 readback", d, 8'h10);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; pwrGood = 1'b0; oePin = 8'hFF; pllLock = 1'b0;
    addrStrap = 2'b01; modeStrap = 2'b00;
    regWrEn = 1'b0; regAddr = 2'd0; regWrData = 8'h00;
    t_reset();
    t_addr();
    t_lock();
    t_gate();
    t_edge();
    t_pwrdown();
    t_bypass();
    t_sw();
    t_freq();
    finishRun();
  end

endmodule